// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column command into the stream of column addresses a memory burst visits. A start strobe captures a starting column, a burst-length code and an order bit. Starting on the next cycle, the block presents one column address per cycle with a valid flag. A last flag marks the final beat.

Every beat of a burst stays inside an aligned block of columns whose size equals the burst length. Only the low address bits move. Two orders are supported. In wrapping-sequential order the low bits count up from the start and wrap inside the block. In interleaved order beat k uses the start's low bits XOR k.

An early-stop input cuts a burst short, as a burst-terminate command would. A fresh start at any time replaces the running burst, as an interrupting column command would. A start with a reserved length code produces no beats and pulses an error flag.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is high and in the cycle after reset, `beat_valid_o`, `beat_last_o` and `len_err_o` are low.
- R2: A start with length code 3'b001, 3'b010 or 3'b011 yields 2, 4 or 8 beats respectively, one per cycle. The first beat is presented in the cycle after the start and equals the start column.
- R3: During a burst, column bits above bit 0 (2 beats), above bit 1 (4 beats) or above bit 2 (8 beats) keep the start column's values on every beat.
- R4: With the order bit at 0, beat k's low bits equal (start low bits + k) modulo the burst length.
- R5: With the order bit at 1, beat k's low bits equal start low bits XOR k. For example, a 4-beat burst from 1 visits 1,0,3,2.
- R6: `beat_last_o` is high on the final beat of a burst and on no other beat. If no start is given in that cycle, `beat_valid_o` is low in the following cycle.
- R7: A start given in the cycle that shows the last beat makes the new burst's first beat appear in the very next cycle, with no idle cycle.
- R8: If `stop_i` is high in a cycle without a start, no further beat of the current burst is presented, and `beat_valid_o` is low from the next cycle.
- R9: A start with a reserved length code (3'b000 or 3'b100 to 3'b111) raises `len_err_o` for exactly one cycle, presents no beats and ends any burst in progress.
- R10: A start given in the middle of a burst abandons it; the new burst's first beat appears in the next cycle. A start takes priority over `stop_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new burst with the captured settings |
| start_col_i | input | 9 | Starting column address |
| len_code_i | input | 3 | Burst-length code: 001=2, 010=4, 011=8, others reserved |
| order_i | input | 1 | Beat order: 0 wrapping-sequential, 1 interleaved |
| stop_i | input | 1 | End the current burst early |
| beat_col_o | output | 9 | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | The presented beat is the final one |
| len_err_o | output | 1 | Pulse after a start with a reserved length code |

## Verification
The properties assume that `start_i`, `stop_i` and the start fields are driven to known levels in every cycle once reset is released. They also assume that the start fields are meaningful only in a cycle where `start_i` is high. The bench changes every input on the falling clock edge only. It holds `start_i` high for exactly one cycle per command, and it keeps the fields steady around the capturing edge. The reserved-code and stop cases are issued only at points where the properties define the next-cycle outcome.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_CODE_2 = 3'b001;
  localparam logic [LEN_CODE_W-1:0] LEN_CODE_4 = 3'b010;
  localparam logic [LEN_CODE_W-1:0] LEN_CODE_8 = 3'b011;

  typedef enum logic {
    ORDER_SEQ  = 1'b0,
    ORDER_XOR  = 1'b1
  } beat_order_e;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  output logic [IDX_W-1:0]      mask_o,
  output logic                  legal_o
);
  always_comb begin
    mask_o  = '0;
    legal_o = 1'b1;
    unique case (code_i)
      LEN_CODE_2: mask_o = IDX_W'(1);
      LEN_CODE_4: mask_o = IDX_W'(3);
      LEN_CODE_8: mask_o = IDX_W'(7);
      default:    legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcs_beat_addr.sv
module bcs_beat_addr
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9,
  parameter int unsigned IDX_W = 3
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] mask_i,
  input  beat_order_e      order_i,
  output logic [COL_W-1:0] col_o
);
  logic [IDX_W-1:0] low_seq;
  logic [IDX_W-1:0] low_xor;
  logic [IDX_W-1:0] low_pick;

  assign low_seq  = base_i[IDX_W-1:0] + idx_i;
  assign low_xor  = base_i[IDX_W-1:0] ^ idx_i;
  assign low_pick = (order_i == ORDER_XOR) ? low_xor : low_seq;

  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_bit
      if (b < IDX_W) begin : g_low
        assign col_o[b] = mask_i[b] ? low_pick[b] : base_i[b];
      end else begin : g_high
        assign col_o[b] = base_i[b];
      end
    end
  endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9,
  parameter int unsigned IDX_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      beat_col_o,
  output logic                  beat_valid_o,
  output logic                  beat_last_o,
  output logic                  len_err_o
);
  logic [IDX_W-1:0] dec_mask;
  logic             dec_legal;

  logic [COL_W-1:0] base_q;
  logic [IDX_W-1:0] mask_q;
  beat_order_e      order_q;
  logic [IDX_W-1:0] idx_q;
  logic [COL_W-1:0] col_q;
  logic             valid_q;
  logic             last_q;
  logic             err_q;
  logic [COL_W-1:0] next_col;
  logic             advance;

  bcs_len_decode #(.IDX_W(IDX_W)) u_dec (
    .code_i  (len_code_i),
    .mask_o  (dec_mask),
    .legal_o (dec_legal)
  );

  bcs_beat_addr #(.COL_W(COL_W), .IDX_W(IDX_W)) u_addr (
    .base_i  (base_q),
    .idx_i   (idx_q),
    .mask_i  (mask_q),
    .order_i (order_q),
    .col_o   (next_col)
  );

  assign advance = valid_q && !last_q && !stop_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      base_q  <= '0;
      mask_q  <= '0;
      order_q <= ORDER_SEQ;
      idx_q   <= '0;
      col_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (start_i) begin
      err_q <= !dec_legal;
      if (dec_legal) begin
        base_q  <= start_col_i;
        mask_q  <= dec_mask;
        order_q <= beat_order_e'(order_i);
        idx_q   <= IDX_W'(1);
        col_q   <= start_col_i;
        valid_q <= 1'b1;
        last_q  <= 1'b0;
      end else begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end
    end else begin
      err_q <= 1'b0;
      if (advance) begin
        col_q   <= next_col;
        last_q  <= (idx_q == mask_q);
        idx_q   <= idx_q + IDX_W'(1);
        valid_q <= 1'b1;
      end else begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end
    end
  end

  assign beat_col_o   = col_q;
  assign beat_valid_o = valid_q;
  assign beat_last_o  = last_q;
  assign len_err_o    = err_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 9,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             stop_i,
  input logic [COL_W-1:0] beat_col_o,
  input logic             beat_valid_o,
  input logic             beat_last_o,
  input logic             len_err_o
);
  logic code_ok;
  assign code_ok = (len_code_i == 3'd1) || (len_code_i == 3'd2) || (len_code_i == 3'd3);

  a_r1_idle_after_reset: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!beat_valid_o && !beat_last_o && !len_err_o));

  a_r2_first_beat: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && code_ok) |=> (beat_valid_o && !beat_last_o && beat_col_o == $past(start_col_i)));

  a_r3_block_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
    (beat_valid_o && !beat_last_o && !start_i && !stop_i) |=>
      (beat_col_o[COL_W-1:IDX_W] == $past(beat_col_o[COL_W-1:IDX_W])));

  a_r6_last_is_valid: assert property (@(posedge clk_i) disable iff (rst_i)
    beat_last_o |-> beat_valid_o);

  a_r6_last_ends: assert property (@(posedge clk_i) disable iff (rst_i)
    (beat_last_o && !start_i) |=> !beat_valid_o);

  a_r8_stop_ends: assert property (@(posedge clk_i) disable iff (rst_i)
    (stop_i && !start_i) |=> !beat_valid_o);

  a_r9_reserved_code: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !code_ok) |=> (len_err_o && !beat_valid_o));

  a_r9_err_single: assert property (@(posedge clk_i) disable iff (rst_i)
    (len_err_o && !start_i) |=> !len_err_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .start_i      (start_i),
  .start_col_i  (start_col_i),
  .len_code_i   (len_code_i),
  .stop_i       (stop_i),
  .beat_col_o   (beat_col_o),
  .beat_valid_o (beat_valid_o),
  .beat_last_o  (beat_last_o),
  .len_err_o    (len_err_o)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [8:0] start_col_i;
  logic [2:0] len_code_i;
  logic       order_i;
  logic       stop_i;
  logic [8:0] beat_col_o;
  logic       beat_valid_o;
  logic       beat_last_o;
  logic       len_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  burst_col_seq dut (
    .clk_i(clk), .rst_i(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
    .beat_col_o(beat_col_o), .beat_valid_o(beat_valid_o),
    .beat_last_o(beat_last_o), .len_err_o(len_err_o)
  );

  typedef struct packed {
    logic [8:0]       col;
    logic [2:0]       code;
    logic             itl;
    logic [3:0]       beats;
    logic [0:7][2:0]  lows;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{9'h105, 3'd1, 1'b0, 4'd2, {3'd5,3'd4,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}},
    '{9'h0A1, 3'd2, 1'b1, 4'd4, {3'd1,3'd0,3'd3,3'd2,3'd0,3'd0,3'd0,3'd0}},
    '{9'h1FF, 3'd2, 1'b0, 4'd4, {3'd7,3'd4,3'd5,3'd6,3'd0,3'd0,3'd0,3'd0}},
    '{9'h02E, 3'd3, 1'b0, 4'd8, {3'd6,3'd7,3'd0,3'd1,3'd2,3'd3,3'd4,3'd5}},
    '{9'h135, 3'd3, 1'b1, 4'd8, {3'd5,3'd4,3'd7,3'd6,3'd1,3'd0,3'd3,3'd2}},
    '{9'h0C3, 3'd2, 1'b0, 4'd4, {3'd3,3'd0,3'd1,3'd2,3'd0,3'd0,3'd0,3'd0}},
    '{9'h07A, 3'd1, 1'b1, 4'd2, {3'd2,3'd3,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}},
    '{9'h000, 3'd3, 1'b1, 4'd8, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}}
  };

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: expected column of beat k, built from R3/R4/R5.
  function automatic int model_col(input int s, input int len, input int itl, input int k);
    int lo = s % len;
    int hi = s - lo;
    int nl = itl ? (lo ^ k) : ((lo + k) % len);
    return hi + nl;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      report();
      $finish;
    end
  end

  task automatic give_start(input logic [8:0] c, input logic [2:0] code, input logic itl);
    start_col_i = c; len_code_i = code; order_i = itl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Called at the negedge right after the start edge; beat 0 is on the outputs.
  task automatic watch_burst(input logic [8:0] c, input int len, input logic itl,
                             input logic chain, input logic [8:0] nc,
                             input logic [2:0] ncode, input logic nitl);
    for (int k = 0; k < len; k++) begin
      int e = model_col(c, len, itl, k);
      check(beat_valid_o, "R2 beat valid", beat_valid_o, 1);
      check(beat_col_o == e[8:0], itl ? "R5 interleaved column" : "R4 sequential column", beat_col_o, e);
      check(beat_last_o == (k == len - 1), "R6 last flag", beat_last_o, k == len - 1);
      if (k == len - 1 && chain) begin
        start_col_i = nc; len_code_i = ncode; order_i = nitl; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    if (!chain) check(!beat_valid_o, "R6 valid drops after last", beat_valid_o, 0);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; start_col_i = '0; len_code_i = 3'd1;
    order_i = 1'b0; stop_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!beat_valid_o && !beat_last_o && !len_err_o, "R1 reset outputs", beat_valid_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!beat_valid_o && !len_err_o, "R1 idle after reset", beat_valid_o, 0);

    // Table walk: R2, R3, R4, R5, R6 against hand-computed orders.
    for (int i = 0; i < 8; i++) begin
      vec_t v = VECS[i];
      give_start(v.col, v.code, v.itl);
      for (int k = 0; k < int'(v.beats); k++) begin
        check(beat_valid_o, "R2 table beat valid", beat_valid_o, 1);
        check(beat_col_o == {v.col[8:3], v.lows[k]}, "R3 R4 R5 table column",
              beat_col_o, {v.col[8:3], v.lows[k]});
        check(beat_last_o == (k == int'(v.beats) - 1), "R6 table last", beat_last_o,
              k == int'(v.beats) - 1);
        @(negedge clk);
      end
      check(!beat_valid_o, "R2 beat count", beat_valid_o, 0);
      @(negedge clk);
    end

    // R7: back-to-back bursts with no gap.
    give_start(9'h1B2, 3'd3, 1'b0);
    watch_burst(9'h1B2, 8, 1'b0, 1'b1, 9'h04D, 3'd2, 1'b1);
    watch_burst(9'h04D, 4, 1'b1, 1'b1, 9'h0F0, 3'd1, 1'b0);
    check(beat_col_o == 9'h0F0 && beat_valid_o, "R7 chained first beat", beat_col_o, 9'h0F0);
    watch_burst(9'h0F0, 2, 1'b0, 1'b0, '0, '0, 1'b0);

    // R8: early stop after the third beat.
    give_start(9'h064, 3'd3, 1'b1);
    @(negedge clk); @(negedge clk);
    check(beat_col_o == 9'h066 && beat_valid_o, "R8 beat before stop", beat_col_o, 9'h066);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check(!beat_valid_o, "R8 no beat after stop", beat_valid_o, 0);
    @(negedge clk);
    check(!beat_valid_o && !beat_last_o, "R8 stays idle", beat_valid_o, 0);

    // R9: reserved codes give an error pulse and no beats.
    begin
      logic [2:0] bad [3] = '{3'd0, 3'd4, 3'd7};
      for (int j = 0; j < 3; j++) begin
        give_start(9'h011, bad[j], 1'b0);
        check(len_err_o, "R9 error raised", len_err_o, 1);
        check(!beat_valid_o, "R9 no beat", beat_valid_o, 0);
        @(negedge clk);
        check(!len_err_o && !beat_valid_o, "R9 error one cycle", len_err_o, 0);
      end
    end
    // R9: reserved start aborts a burst in progress.
    give_start(9'h120, 3'd3, 1'b0);
    give_start(9'h033, 3'd5, 1'b0);
    check(len_err_o && !beat_valid_o, "R9 abort running burst", beat_valid_o, 0);
    @(negedge clk);

    // R10: restart mid-burst, with stop high in the same cycle.
    give_start(9'h080, 3'd3, 1'b0);
    @(negedge clk);
    stop_i = 1'b1;
    give_start(9'h157, 3'd2, 1'b1);
    stop_i = 1'b0;
    check(beat_col_o == 9'h157 && beat_valid_o, "R10 restart first beat", beat_col_o, 9'h157);
    @(negedge clk);
    check(beat_col_o == 9'h156, "R10 restart second beat", beat_col_o, 9'h156);
    @(negedge clk); @(negedge clk);
    check(beat_last_o && beat_col_o == 9'h154, "R10 restart last beat", beat_col_o, 9'h154);

    report();
    $finish;
  end
endmodule